// File: doc/BRIEF.md
# Single-Cycle Unaligned Word Memory

This block is a byte-addressable storage array with a 32-bit data port. It accepts a read or a write of a full word at any byte address and completes it in one cycle, including when the word crosses a row boundary. Four independent byte-wide banks make up the array, and each bank receives its own row index. A bank whose lane number is below the low two address bits receives the row after the base row. This lets the four bytes of an unaligned word come from two neighbouring rows in the same cycle.

Rotators sit between the bank lanes and the port. On writes, data and lane enables rotate toward higher lanes by the byte offset. On reads, the registered bank outputs rotate back, so the byte at the requested address appears in the least significant byte of the port. A write can store one, two or four consecutive bytes. Reads always return four bytes. The array depth is set by a row-width parameter, and an access that runs past the last byte continues at byte 0.

Top module: `unaligned_mem`

## Requirements
- R1: A read request at any byte address A returns the bytes at A, A+1, A+2 and A+3 on `rdata` bits [7:0], [15:8], [23:16] and [31:24] respectively.
- R2: A write with `size` = 2'b10 at any byte address A stores `wdata` byte j (bits [8j+7:8j]) at address A+j for j = 0..3.
- R3: A write with `size` = 2'b01 at address A stores `wdata` bits [7:0] at A and bits [15:8] at A+1, and leaves every other byte unchanged.
- R4: A write with `size` = 2'b00 at address A stores `wdata` bits [7:0] at A and leaves every other byte unchanged.
- R5: A write with `size` = 2'b11 leaves the whole memory unchanged.
- R6: Byte addresses that run past the highest byte of the memory continue at byte address 0, for both reads and writes.
- R7: `rvalid` is high in the cycle after a cycle with `req` = 1 and `we` = 0, and low after any other cycle. Read data appears together with `rvalid`.
- R8: A read issued in the cycle right after a write returns the data that the write stored.
- R9: After reset, `rvalid` is 0 and `rdata` is 0 until the first read completes.
- R10: Reads issued on consecutive cycles each return their own word one cycle later, with no idle cycles needed between them.
- R11: With `req` = 0, no byte of the memory changes, whatever `we`, `size` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+2 | Byte address of the first byte of the access |
| size | input | 2 | Write width: 00 one byte, 01 two bytes, 10 four bytes, 11 none |
| wdata | input | 32 | Write data, first byte in bits [7:0] |
| rdata | output | 32 | Read data, first byte in bits [7:0] |
| rvalid | output | 1 | High when `rdata` holds the result of the previous cycle's read |

## Verification
The assertions check the following on every cycle:
- the read-valid timing;
- the number of lanes each write size enables;
- that idle cycles and the reserved size enable no lane;
- the reset state of the outputs;
- that a word written and then read back at the same address comes out intact.

Only the bench's sweeps over every byte address can show the rest. That covers the byte order across an offset, which neighbouring bytes a partial write leaves untouched, and the wrap from the last row to row 0.

// File: rtl/umem_pkg.sv
package umem_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int PORT_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_NONE = 2'b11
    } xfer_size_e;

    // Lanes touched by a write, before rotation to the start lane
    function automatic logic [LANES-1:0] size_mask(xfer_size_e s);
        case (s)
            SZ_BYTE: return 4'b0001;
            SZ_HALF: return 4'b0011;
            SZ_WORD: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [LANES-1:0] rotl_mask(logic [LANES-1:0] m,
                                                   logic [OFF_W-1:0] o);
        logic [2*LANES-1:0] t;
        t = {m, m} << o;
        return t[2*LANES-1:LANES];
    endfunction

    function automatic logic [PORT_W-1:0] rotl_bytes(logic [PORT_W-1:0] d,
                                                     logic [OFF_W-1:0] o);
        logic [2*PORT_W-1:0] t;
        t = {d, d} << (LANE_W * o);
        return t[2*PORT_W-1:PORT_W];
    endfunction

    function automatic logic [PORT_W-1:0] rotr_bytes(logic [PORT_W-1:0] d,
                                                     logic [OFF_W-1:0] o);
        logic [2*PORT_W-1:0] t;
        t = {d, d} >> (LANE_W * o);
        return t[PORT_W-1:0];
    endfunction

    typedef struct packed {
        logic             valid;
        logic [OFF_W-1:0] off;
    } rd_tag_t;

endpackage

// File: rtl/umem_lane_router.sv
module umem_lane_router
    import umem_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int ADDR_W = ROW_W + OFF_W
) (
    input  logic                          req,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  xfer_size_e                    size,
    input  logic [PORT_W-1:0]             wdata,
    output logic [LANES-1:0][ROW_W-1:0]   bank_row,
    output logic [LANES-1:0]              bank_we,
    output logic [LANES-1:0][LANE_W-1:0]  bank_wdata
);
    logic [OFF_W-1:0]  off;
    logic [ROW_W-1:0]  base_row;
    logic [PORT_W-1:0] wdata_rot;
    logic [LANES-1:0]  mask_rot;

    assign off       = addr[OFF_W-1:0];
    assign base_row  = addr[ADDR_W-1:OFF_W];
    assign wdata_rot = rotl_bytes(wdata, off);
    assign mask_rot  = rotl_mask(size_mask(size), off);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Lanes below the start offset hold the tail of the word, one row up;
        // the add truncates, so the last row wraps to row 0.
        assign bank_row[k]   = base_row + ROW_W'(OFF_W'(k) < off);
        assign bank_we[k]    = req && we && mask_rot[k];
        assign bank_wdata[k] = wdata_rot[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/umem_byte_bank.sv
module umem_byte_bank
    import umem_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[row] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= store[row];
        end
    end

endmodule

// File: rtl/umem_read_align.sv
module umem_read_align
    import umem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [OFF_W-1:0]  off,
    input  logic [PORT_W-1:0] lane_rdata,
    output logic [PORT_W-1:0] rdata,
    output logic              rvalid
);
    rd_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.valid <= rd_req;
            if (rd_req) begin
                tag_q.off <= off;
            end
        end
    end

    assign rdata  = rotr_bytes(lane_rdata, tag_q.off);
    assign rvalid = tag_q.valid;

endmodule

// File: rtl/unaligned_mem.sv
module unaligned_mem
    import umem_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int ADDR_W = ROW_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid
);
    logic [LANES-1:0][ROW_W-1:0]  bank_row;
    logic [LANES-1:0]             bank_we;
    logic [LANES-1:0][LANE_W-1:0] bank_wdata;
    logic [PORT_W-1:0]            lane_rdata;
    logic                         rd_req;

    assign rd_req = req && !we;

    umem_lane_router #(.ROW_W(ROW_W)) u_router (
        .req        (req),
        .we         (we),
        .addr       (addr),
        .size       (xfer_size_e'(size)),
        .wdata      (wdata),
        .bank_row   (bank_row),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        umem_byte_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bank_we[k]),
            .rd_en (rd_req),
            .row   (bank_row[k]),
            .wdata (bank_wdata[k]),
            .rdata (lane_rdata[k*LANE_W +: LANE_W])
        );
    end

    umem_read_align u_align (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .off        (addr[OFF_W-1:0]),
        .lane_rdata (lane_rdata),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

endmodule

// File: rtl/umem_checker.sv
module umem_checker #(
    parameter int ROW_W = 8,
    localparam int ADDR_W = ROW_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              rvalid,
    input logic [3:0]        bank_we
);
    assert_rvalid_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !we) |=> rvalid);

    assert_rvalid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !(req && !we) |=> !rvalid);

    assert_word_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (req && we && size == 2'b10) |-> $countones(bank_we) == 4);

    assert_half_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (req && we && size == 2'b01) |-> $countones(bank_we) == 2);

    assert_byte_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (req && we && size == 2'b00) |-> $countones(bank_we) == 1);

    assert_reserved_size_R5: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b11) |-> bank_we == 4'b0000);

    assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        !req |-> bank_we == 4'b0000);

    assert_reset_outputs_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rvalid && rdata == 32'h0));

    assert_write_then_read_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(req && !we, 1) && $past(req && we && size == 2'b10, 2)
         && $past(addr, 1) == $past(addr, 2))
        |-> rdata == $past(wdata, 2));

endmodule

bind unaligned_mem umem_checker #(.ROW_W(ROW_W)) u_umem_checker (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .size    (size),
    .wdata   (wdata),
    .rdata   (rdata),
    .rvalid  (rvalid),
    .bank_we (bank_we)
);

// File: tb/unaligned_mem_bench.sv
module unaligned_mem_bench;
    localparam int ROW_W  = 3;
    localparam int ADDR_W = ROW_W + 2;
    localparam int NBYTES = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        size = 2'b10;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid;

    logic [7:0] mref [NBYTES];
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    unaligned_mem #(.ROW_W(ROW_W)) u_unaligned_mem (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] r;
        for (int j = 0; j < 4; j++) r[8*j +: 8] = mref[(a + j) % NBYTES];
        return r;
    endfunction

    function automatic logic [31:0] pattern(input int a, input int salt);
        return {8'(a * 7 + salt), 8'(a * 5 + 1 + salt), 8'(a * 3 + 9 + salt), 8'(a + 64 + salt)};
    endfunction

    // Drive one cycle from a falling edge; returns at the next falling edge
    task automatic drive(input logic r, input logic w, input int a,
                         input logic [1:0] s, input logic [31:0] d);
        int n;
        req = r; we = w; addr = ADDR_W'(a); size = s; wdata = d;
        @(negedge clk);
        if (r && w) begin
            n = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 0;
            for (int j = 0; j < n; j++) mref[(a + j) % NBYTES] = d[8*j +: 8];
        end
    endtask

    task automatic rd_check(input int a, input string tag);
        drive(1'b1, 1'b0, a, 2'b10, 32'h0);
        chk(tag, rdata, exp_word(a));
        chk({tag, "_rvalid"}, {31'h0, rvalid}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9_rvalid", {31'h0, rvalid}, 32'h0);
        chk("R9_rdata", rdata, 32'h0);

        // Fill with aligned word writes
        for (int a = 0; a < NBYTES; a += 4) drive(1'b1, 1'b1, a, 2'b10, pattern(a, 11));
        chk("R7_idle", {31'h0, rvalid}, 32'h0);

        // R10: back-to-back reads over every byte address (R1 ordering)
        for (int a = 0; a < NBYTES; a++) rd_check(a, "R10_R1");
        drive(1'b0, 1'b0, 0, 2'b10, 32'h0);
        chk("R7_after_read", {31'h0, rvalid}, 32'h0);

        // R2 word writes at each address, read at once (R8) and offset (R1)
        for (int a = 0; a < NBYTES; a++) begin
            drive(1'b1, 1'b1, a, 2'b10, pattern(a, 37));
            rd_check(a, "R8");
            rd_check((a + 2) % NBYTES, "R2");
            if (a >= NBYTES - 3) rd_check(0, "R6");
        end

        // R3 half writes, check neighbours untouched
        for (int a = 0; a < NBYTES; a++) begin
            drive(1'b1, 1'b1, a, 2'b01, pattern(a, 91));
            rd_check((a + NBYTES - 1) % NBYTES, "R3");
        end

        // R4 byte writes
        for (int a = 0; a < NBYTES; a++) begin
            drive(1'b1, 1'b1, a, 2'b00, pattern(a, 150));
            rd_check((a + NBYTES - 2) % NBYTES, "R4");
            rd_check(a, "R4");
        end

        // R6 wrap: word write at the last byte
        drive(1'b1, 1'b1, NBYTES - 1, 2'b10, 32'hDEADBEEF);
        rd_check(0, "R6");
        rd_check(NBYTES - 2, "R6");

        // R5 reserved size writes nothing
        for (int a = 0; a < NBYTES; a += 3) begin
            drive(1'b1, 1'b1, a, 2'b11, 32'hFFFFFFFF);
            rd_check(a, "R5");
        end

        // R11 no request, no write
        for (int a = 0; a < NBYTES; a += 5) begin
            drive(1'b0, 1'b1, a, 2'b10, 32'h5A5A5A5A);
            chk("R11_rvalid", {31'h0, rvalid}, 32'h0);
            rd_check(a, "R11");
        end

        finish_run();
    end

endmodule